// File: doc/BRIEF.md
# Interrupt Controller Command Word Sequencer

This block is the host-facing programming front end of an interrupt controller. A processor writes bytes through a small register port: chip select, active-low read and write strobes, one address bit and an 8-bit data bus. The block turns those writes into a fixed initialisation sequence and, once that sequence is complete, into operational commands. Its outputs are the configuration that the interrupt-handling logic elsewhere consumes:

- trigger style;
- single or cascaded operation;
- vector base;
- cascade map or slave identity;
- extra mode word;
- mask;
- end-of-interrupt strobes;
- which status register a read returns.

The interrupt handling itself sits outside. Its in-service and pending vectors come in only so that the host can read them back.

The sequencer is a five-state machine:

- `ST_UNINIT` is the state after reset. Only a start word leaves it.
- `ST_WAIT_BASE` waits for the vector base.
- `ST_WAIT_CASC` waits for the cascade word.
- `ST_WAIT_MODE` waits for the mode word.
- `ST_READY` accepts operational commands.

Every transition is listed below:

| Transition | Taken when |
| --- | --- |
| Any state to `ST_WAIT_BASE` | A start word is written. |
| `ST_WAIT_BASE` to `ST_WAIT_CASC` | A data write arrives and cascade operation was chosen. |
| `ST_WAIT_BASE` to `ST_WAIT_MODE` | A data write arrives, single operation was chosen and a mode word was requested. |
| `ST_WAIT_BASE` to `ST_READY` | A data write arrives, single operation was chosen and no mode word was requested. |
| `ST_WAIT_CASC` to `ST_WAIT_MODE` | A data write arrives and a mode word was requested. |
| `ST_WAIT_CASC` to `ST_READY` | A data write arrives and no mode word was requested. |
| `ST_WAIT_MODE` to `ST_READY` | A data write arrives. |

`ST_READY` is left only by a new start word.

Top module: `irq_cmd_sequencer`

## Requirements
- R1: After reset the block is uninitialised (`init_done`=0). `mask`, `vec_base`, `casc_map`, `mode_word`, `eoi_cmd` and the trigger and mode flags are 0, `eoi_pulse` is 0, and `rsel_isr`=0 (pending selected).
- R2: A write with `addr`=0 and data bit 4 = 1 is a start word, and it restarts the sequence from any state. It latches bit 3 into `cfg_level`, bit 1 into `cfg_single` and bit 0 into `cfg_need_mode`. It ignores bits 7..5 and bit 2. It clears `mask` and sets `rsel_isr`=0.
- R3: The first `addr`=1 write after a start word loads `vec_base` with the full data byte.
- R4: The next `addr`=1 write loads `casc_map` only when `cfg_single`=0. `casc_id` always shows `casc_map` bits 2..0. With `cfg_single`=1 this step is skipped.
- R5: The `addr`=1 write after that loads `mode_word` only when `cfg_need_mode`=1. Otherwise this step is skipped. `init_done` rises with the last expected word.
- R6: Before the first start word, every write is ignored. During the sequence, `addr`=0 writes that are not start words are ignored.
- R7: With `init_done`=1, an `addr`=1 write loads `mask`.
- R8: With `init_done`=1, an `addr`=0 write with data bits 4 and 3 both 0 raises `eoi_pulse` for exactly one cycle and stores the byte in `eoi_cmd`.
- R9: With `init_done`=1, an `addr`=0 write with bit 4 = 0 and bit 3 = 1 sets the read selection from bits 1..0. The value 2'b10 selects pending, 2'b11 selects in-service, and a 0 in bit 1 leaves the selection unchanged.
- R10: While `cs_n` and `rd_n` are both low, `rdata` returns `mask` for `addr`=1. For `addr`=0 it returns `isr_in` if in-service is selected, else `irr_in`. Otherwise `rdata` is 0.
- R11: One low period of the write strobe under chip select is one write, however many cycles it lasts. The write takes effect at the first clock edge of that period.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Register address bit |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, 0 when not reading |
| isr_in | input | DW | In-service vector for read-back |
| irr_in | input | DW | Pending-request vector for read-back |
| init_done | output | 1 | Initialisation sequence complete |
| cfg_level | output | 1 | 1 = level-triggered inputs, 0 = edge |
| cfg_single | output | 1 | 1 = single, 0 = cascaded |
| cfg_need_mode | output | 1 | Mode word requested in the sequence |
| vec_base | output | DW | Vector base type number |
| casc_map | output | DW | Cascade word (slave map for a master) |
| casc_id | output | ID_W | Low bits of cascade word (slave identity) |
| mode_word | output | DW | Optional mode word |
| mask | output | DW | Interrupt mask |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_cmd | output | DW | Last end-of-interrupt command byte |
| rsel_isr | output | 1 | 1 = reads at addr 0 return in-service |

## Verification
The bench builds the block with `DW`=8 and `ID_W`=3. Every command bit position the decoder looks at is therefore reachable with a plain byte, and random data fills the ignored bits 7..5 and bit 2 of start words. Random traffic mixes restarts, which can land at any point of the sequence, with data, end-of-interrupt and read-select writes and with strobes held for one to three cycles. All four combinations of single/cascaded and mode-word requested/not requested are therefore walked, as are pre-init writes and mid-sequence restarts. Directed cases add the reset state, each skip path and a long-held end-of-interrupt strobe.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT    = 3'd0,
        ST_WAIT_BASE = 3'd1,
        ST_WAIT_CASC = 3'd2,
        ST_WAIT_MODE = 3'd3,
        ST_READY     = 3'd4
    } seq_state_t;

    typedef enum logic [2:0] {
        WK_NONE  = 3'd0,
        WK_START = 3'd1,
        WK_DATA  = 3'd2,
        WK_EOI   = 3'd3,
        WK_RSEL  = 3'd4
    } word_kind_t;

    // Bit positions inside command bytes
    localparam int START_BIT  = 4;
    localparam int CMD_BIT    = 3;
    localparam int LEVEL_BIT  = 3;
    localparam int SINGLE_BIT = 1;
    localparam int MODE_BIT   = 0;
    localparam int RSEL_EN    = 1;
    localparam int RSEL_ISR   = 0;

endpackage

// File: rtl/irqseq_bus.sv
module irqseq_bus (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_fire,
    output logic rd_act
);
    logic wr_act;
    logic wr_act_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
        end else begin
            wr_act_q <= wr_act;
        end
    end

    // One write per strobe low period
    assign wr_fire = wr_act && !wr_act_q;

    p_single_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    p_hold_no_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && $past(wr_act)) |-> !wr_fire);

endmodule

// File: rtl/irqseq_decode.sv
module irqseq_decode
    import irqseq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          wr_fire,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output word_kind_t    kind
);
    always_comb begin
        kind = WK_NONE;
        if (wr_fire) begin
            if (addr) begin
                kind = WK_DATA;
            end else if (wdata[START_BIT]) begin
                kind = WK_START;
            end else if (wdata[CMD_BIT]) begin
                kind = WK_RSEL;
            end else begin
                kind = WK_EOI;
            end
        end
    end

    always_comb begin
        if (!wr_fire) begin
            p_idle_kind_r11: assert (kind == WK_NONE);
        end
    end

endmodule

// File: rtl/irqseq_fsm.sv
module irqseq_fsm
    import irqseq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  word_kind_t    kind,
    input  logic [DW-1:0] wdata,
    output logic          init_done,
    output logic          cfg_level,
    output logic          cfg_single,
    output logic          cfg_need_mode,
    output logic [DW-1:0] vec_base,
    output logic [DW-1:0] casc_map,
    output logic [DW-1:0] mode_word,
    output logic [DW-1:0] mask,
    output logic          eoi_pulse,
    output logic [DW-1:0] eoi_cmd,
    output logic          rsel_isr
);
    seq_state_t state;
    seq_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_UNINIT;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (kind == WK_START) begin
            state_nx = ST_WAIT_BASE;
        end else if (kind == WK_DATA) begin
            unique case (state)
                ST_UNINIT:    state_nx = ST_UNINIT;
                ST_WAIT_BASE: begin
                    if (!cfg_single) begin
                        state_nx = ST_WAIT_CASC;
                    end else if (cfg_need_mode) begin
                        state_nx = ST_WAIT_MODE;
                    end else begin
                        state_nx = ST_READY;
                    end
                end
                ST_WAIT_CASC: state_nx = cfg_need_mode ? ST_WAIT_MODE : ST_READY;
                ST_WAIT_MODE: state_nx = ST_READY;
                ST_READY:     state_nx = ST_READY;
                default:      state_nx = ST_UNINIT;
            endcase
        end
    end

    // Output and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_level     <= 1'b0;
            cfg_single    <= 1'b0;
            cfg_need_mode <= 1'b0;
            vec_base      <= '0;
            casc_map      <= '0;
            mode_word     <= '0;
            mask          <= '0;
            eoi_pulse     <= 1'b0;
            eoi_cmd       <= '0;
            rsel_isr      <= 1'b0;
        end else begin
            eoi_pulse <= 1'b0;
            if (kind == WK_START) begin
                cfg_level     <= wdata[LEVEL_BIT];
                cfg_single    <= wdata[SINGLE_BIT];
                cfg_need_mode <= wdata[MODE_BIT];
                mask          <= '0;
                rsel_isr      <= 1'b0;
            end else begin
                unique case (state)
                    ST_UNINIT: begin
                    end
                    ST_WAIT_BASE: begin
                        if (kind == WK_DATA) vec_base <= wdata;
                    end
                    ST_WAIT_CASC: begin
                        if (kind == WK_DATA) casc_map <= wdata;
                    end
                    ST_WAIT_MODE: begin
                        if (kind == WK_DATA) mode_word <= wdata;
                    end
                    ST_READY: begin
                        if (kind == WK_DATA) begin
                            mask <= wdata;
                        end else if (kind == WK_EOI) begin
                            eoi_pulse <= 1'b1;
                            eoi_cmd   <= wdata;
                        end else if (kind == WK_RSEL && wdata[RSEL_EN]) begin
                            rsel_isr <= wdata[RSEL_ISR];
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign init_done = (state == ST_READY);

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_START) |=> (state == ST_WAIT_BASE) && (mask == '0) && !rsel_isr);

    p_uninit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNINIT && kind != WK_START) |=> (state == ST_UNINIT));

    p_skip_casc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_BASE && kind == WK_DATA && cfg_single) |=> (state != ST_WAIT_CASC));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WK_START && !(kind == WK_DATA && state == ST_READY)) |=> $stable(mask));

    p_eoi_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> init_done);

    p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |=> !eoi_pulse);

endmodule

// File: rtl/irq_cmd_sequencer.sv
module irq_cmd_sequencer
    import irqseq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [DW-1:0]   isr_in,
    input  logic [DW-1:0]   irr_in,
    output logic            init_done,
    output logic            cfg_level,
    output logic            cfg_single,
    output logic            cfg_need_mode,
    output logic [DW-1:0]   vec_base,
    output logic [DW-1:0]   casc_map,
    output logic [ID_W-1:0] casc_id,
    output logic [DW-1:0]   mode_word,
    output logic [DW-1:0]   mask,
    output logic            eoi_pulse,
    output logic [DW-1:0]   eoi_cmd,
    output logic            rsel_isr
);
    logic       wr_fire;
    logic       rd_act;
    word_kind_t kind;

    irqseq_bus u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .wr_fire (wr_fire),
        .rd_act  (rd_act)
    );

    irqseq_decode #(.DW(DW)) u_decode (
        .wr_fire (wr_fire),
        .addr    (addr),
        .wdata   (wdata),
        .kind    (kind)
    );

    irqseq_fsm #(.DW(DW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .kind          (kind),
        .wdata         (wdata),
        .init_done     (init_done),
        .cfg_level     (cfg_level),
        .cfg_single    (cfg_single),
        .cfg_need_mode (cfg_need_mode),
        .vec_base      (vec_base),
        .casc_map      (casc_map),
        .mode_word     (mode_word),
        .mask          (mask),
        .eoi_pulse     (eoi_pulse),
        .eoi_cmd       (eoi_cmd),
        .rsel_isr      (rsel_isr)
    );

    assign casc_id = casc_map[ID_W-1:0];

    always_comb begin
        rdata = '0;
        if (rd_act) begin
            if (addr) begin
                rdata = mask;
            end else begin
                rdata = rsel_isr ? isr_in : irr_in;
            end
        end
    end

    p_eoi_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoi_pulse) |-> $past(wr_fire) && !$past(addr));

endmodule

// File: tb/test_irq_cmd_sequencer.sv
module test_irq_cmd_sequencer;
    localparam int DW   = 8;
    localparam int ID_W = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          addr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [DW-1:0] isr_in = '0;
    logic [DW-1:0] irr_in = '0;
    logic          init_done, cfg_level, cfg_single, cfg_need_mode;
    logic [DW-1:0] vec_base, casc_map, mode_word, mask, eoi_cmd;
    logic [ID_W-1:0] casc_id;
    logic          eoi_pulse, rsel_isr;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Bench model state: 0 uninit, 1 base, 2 cascade, 3 mode, 4 ready
    int            ms;
    bit            m_level, m_single, m_need;
    logic [DW-1:0] m_base, m_map, m_mode, m_mask, m_eoi;
    bit            m_rsel;
    bit            m_pulse;

    always #5 clk = ~clk;

    irq_cmd_sequencer #(.DW(DW), .ID_W(ID_W)) i_irq_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .isr_in(isr_in), .irr_in(irr_in),
        .init_done(init_done), .cfg_level(cfg_level), .cfg_single(cfg_single),
        .cfg_need_mode(cfg_need_mode), .vec_base(vec_base), .casc_map(casc_map),
        .casc_id(casc_id), .mode_word(mode_word), .mask(mask), .eoi_pulse(eoi_pulse),
        .eoi_cmd(eoi_cmd), .rsel_isr(rsel_isr)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp_v);
        end
    endtask

    task automatic model_reset();
        ms = 0; m_level = 0; m_single = 0; m_need = 0;
        m_base = '0; m_map = '0; m_mode = '0; m_mask = '0; m_eoi = '0;
        m_rsel = 0; m_pulse = 0;
    endtask

    function automatic int after_base(input bit single, input bit need);
        if (!single) return 2;
        return need ? 3 : 4;
    endfunction

    task automatic model_write(input bit a, input logic [DW-1:0] d);
        m_pulse = 0;
        if (!a && d[4]) begin
            m_level = d[3]; m_single = d[1]; m_need = d[0];
            m_mask = '0; m_rsel = 0; ms = 1;
        end else if (ms == 1) begin
            if (a) begin m_base = d; ms = after_base(m_single, m_need); end
        end else if (ms == 2) begin
            if (a) begin m_map = d; ms = m_need ? 3 : 4; end
        end else if (ms == 3) begin
            if (a) begin m_mode = d; ms = 4; end
        end else if (ms == 4) begin
            if (a) m_mask = d;
            else if (!d[3]) begin m_pulse = 1; m_eoi = d; end
            else if (d[1]) m_rsel = d[0];
        end
    endtask

    task automatic compare_all();
        chk("R5 init_done", {7'd0, init_done}, {7'd0, ms == 4});
        chk("R2 cfg_level", {7'd0, cfg_level}, {7'd0, m_level});
        chk("R2 cfg_single", {7'd0, cfg_single}, {7'd0, m_single});
        chk("R2 cfg_need_mode", {7'd0, cfg_need_mode}, {7'd0, m_need});
        chk("R3 vec_base", vec_base, m_base);
        chk("R4 casc_map", casc_map, m_map);
        chk("R4 casc_id", {5'd0, casc_id}, {5'd0, m_map[2:0]});
        chk("R5 mode_word", mode_word, m_mode);
        chk("R7 mask", mask, m_mask);
        chk("R8 eoi_cmd", eoi_cmd, m_eoi);
        chk("R9 rsel_isr", {7'd0, rsel_isr}, {7'd0, m_rsel});
    endtask

    // Write held low for 'hold' cycles; counts eoi pulses seen
    task automatic do_write(input bit a, input logic [DW-1:0] d, input int hold);
        int pulses = 0;
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = a; wdata = d;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (eoi_pulse) pulses++;
        end
        wr_n = 1; cs_n = 1;
        model_write(a, d);
        chk("R8 R11 eoi pulse count", pulses[DW-1:0], {7'd0, m_pulse});
        compare_all();
        @(negedge clk);
        chk("R8 eoi pulse low after", {7'd0, eoi_pulse}, 8'd0);
    endtask

    task automatic do_reads();
        logic [DW-1:0] iv, pv;
        iv = DW'($urandom); pv = DW'($urandom);
        @(negedge clk);
        isr_in = iv; irr_in = pv;
        chk("R10 idle rdata", rdata, '0);
        cs_n = 0; rd_n = 0; addr = 1;
        #1 chk("R10 read mask", rdata, m_mask);
        addr = 0;
        #1 chk("R10 R9 read status", rdata, m_rsel ? iv : pv);
        @(negedge clk);
        rd_n = 1; cs_n = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all();
        chk("R1 eoi_pulse", {7'd0, eoi_pulse}, 8'd0);
        rst_n = 1;
        @(negedge clk);
        // R6: writes ignored before any start word
        do_write(1, 8'hA5, 1);
        do_write(0, 8'h00, 1);
        do_write(0, 8'h0B, 1);
        chk("R6 uninit mask", mask, 8'h00);
        // R2 R3 R5: single, no mode word, ignored high bits
        do_write(0, 8'hF2, 1);
        do_write(0, 8'h05, 1);              // R6 ignored mid-sequence
        do_write(1, 8'h40, 1);
        chk("R4 skip to ready", {7'd0, init_done}, 8'd1);
        do_write(1, 8'h3C, 1);
        do_reads();
        // R8 R11: held end-of-interrupt strobe
        do_write(0, 8'h20, 3);
        // R9: select in-service, then no-change form
        do_write(0, 8'h0B, 1);
        do_reads();
        do_write(0, 8'h09, 1);
        do_reads();
        // R4 R5: cascade with mode word
        do_write(0, 8'h19, 2);
        chk("R2 mask cleared", mask, 8'h00);
        do_write(1, 8'h08, 1);
        do_write(1, 8'h86, 1);
        do_write(1, 8'h1D, 1);
        do_reads();
        // R2: restart in the middle of the sequence
        do_write(0, 8'h10, 1);
        do_write(1, 8'h50, 1);
        do_write(0, 8'h13, 1);
        do_write(1, 8'h60, 1);
        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [DW-1:0] d;
            r = int'($urandom % 16);
            d = DW'($urandom);
            if (r == 0) do_write(0, d | 8'h10, 1 + int'($urandom % 3));
            else if (r <= 6) do_write(1, d, 1 + int'($urandom % 3));
            else if (r <= 9) do_write(0, d & 8'hE7, 1 + int'($urandom % 3));
            else if (r <= 12) do_write(0, (d & 8'hEF) | 8'h08, 1);
            else do_reads();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule